// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host side of a three-wire link to a 12-bit sampling converter. On request it raises a conversion strobe and then runs a free-running serial clock derived from the system clock. While that clock runs it shifts the converter's serial output into a word. Each frame carries a reference-ready flag ahead of the twelve result bits, most significant bit first. The block hands the collected word to the downstream logic as one formatted 16-bit result, using a valid/ready pair.

The same two lines also carry power commands. A nap command gives two strobe pulses with the clock held low. A sleep command gives four such pulses. A wake command gives one clock pulse of a fixed width with the strobe held low. The `bipolar` input, sampled when a frame starts, picks the result format: plain straight binary, or two's complement with the sign copied into the spare high bits.

Back-pressure rules: `res_valid` rises when a frame ends. It stays high, with `res_data` unchanged, until a cycle in which `res_ready` is high. The block stays busy until then, and it accepts no new request while busy. `res_ready` has no effect while `res_valid` is low.

Top module: `adc_link_ctrl`

## Requirements
- R1: After reset `conv_o` and `sclk_o` are low, `busy` is low and `res_valid` is low.
- R2: A frame raises `conv_o` for one half serial period while `sclk_o` is low. `conv_o` then returns low before the first rising edge of `sclk_o`. The frame gives exactly FRAME_CLKS (16) rising edges of `sclk_o`, and `conv_o` is never high while `sclk_o` is high.
- R3: `sdata_i` is sampled just before each rising edge of `sclk_o`. The values seen at rising edges 3 through 15 are the ready flag, then result bits 11 down to 0.
- R4: With `bipolar` low at the start, `res_data` bits 11:0 hold the result, bit 12 holds the ready flag and bits 15:13 are zero.
- R5: With `bipolar` high at the start, bits 11:0 and bit 12 are as in R4, and each of bits 15:13 equals result bit 11.
- R6: `res_valid` stays high and `res_data` stays stable until `res_ready` is high. `busy` stays high the whole time `res_valid` is high.
- R7: Any request made while `busy` is high is ignored. No extra `conv_o` or `sclk_o` pulse appears for it.
- R8: `nap_req` in an idle cycle gives exactly two `conv_o` pulses and no `sclk_o` edge.
- R9: `sleep_req` in an idle cycle gives exactly four `conv_o` pulses and no `sclk_o` edge.
- R10: `wake_req` in an idle cycle gives one `sclk_o` pulse, high for WAKE_HALVES*DIV_HALF (4) system cycles, and no `conv_o` pulse.
- R11: When several requests arrive in the same idle cycle, the priority is conversion, then sleep, then nap, then wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_req | input | 1 | Request one conversion frame |
| nap_req | input | 1 | Request the light power-down sequence |
| sleep_req | input | 1 | Request the deep power-down sequence |
| wake_req | input | 1 | Request a wake-up clock pulse |
| bipolar | input | 1 | Result format select, sampled at frame start |
| busy | output | 1 | A frame or command is in progress |
| conv_o | output | 1 | Conversion strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdata_i | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Formatted result available |
| res_ready | input | 1 | Downstream accepts the result |
| res_data | output | 16 | Formatted result word |

## Verification
Two requests can reach the idle controller in the same cycle. The bench raises `conv_req` together with `sleep_req` and `nap_req` in one cycle. It then checks that a single frame runs, with one strobe, and delivers a correct word. Two more cases pair sleep with nap, and nap with wake. The bench judges each by counting strobe and clock edges, and these counts must match the winner alone. The bench also sends a conversion or sleep request while a frame is still running. No pulse may be added for it.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CLOCK,
    ST_HOLD,
    ST_PWR_HI,
    ST_PWR_LO,
    ST_WAKE
  } link_st_e;

  localparam int unsigned NAP_PULSES   = 2;
  localparam int unsigned SLEEP_PULSES = 4;
endpackage

// File: rtl/half_tick.sv
module half_tick #(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = $clog2(DIV_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!en)     cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bit_capture.sv
module bit_capture #(
  parameter int unsigned BITS = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            shift,
  input  logic            din,
  output logic [BITS-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clr)    q <= '0;
    else if (shift)  q <= {q[BITS-2:0], din};
  end
endmodule

// File: rtl/word_format.sv
module word_format #(
  parameter int unsigned DW = 12,
  parameter int unsigned OW = 16
) (
  input  logic [DW:0]   raw,
  input  logic          bip,
  output logic [OW-1:0] word
);
  localparam int unsigned PAD = OW - DW - 1;

  generate
    if (PAD > 0) begin : g_pad
      assign word = {{PAD{bip & raw[DW-1]}}, raw};
    end else begin : g_nopad
      assign word = raw[OW-1:0];
    end
  endgenerate
endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl #(
  parameter int unsigned DIV_HALF    = 2,
  parameter int unsigned DW          = 12,
  parameter int unsigned OW          = 16,
  parameter int unsigned LEAD        = 2,
  parameter int unsigned FRAME_CLKS  = 16,
  parameter int unsigned WAKE_HALVES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_req,
  input  logic          nap_req,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic          bipolar,
  output logic          busy,
  output logic          conv_o,
  output logic          sclk_o,
  input  logic          sdata_i,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [OW-1:0] res_data
);
  import adc_link_pkg::*;

  localparam int unsigned RCW = $clog2(FRAME_CLKS + 1);
  localparam int unsigned WCW = $clog2(WAKE_HALVES + 1);
  localparam logic [RCW-1:0] RC_LAST  = RCW'(FRAME_CLKS);
  localparam logic [RCW-1:0] CAP_LO   = RCW'(LEAD);
  localparam logic [RCW-1:0] CAP_HI   = RCW'(LEAD + DW + 1);
  localparam logic [WCW-1:0] WAKE_END = WCW'(WAKE_HALVES - 1);

  link_st_e       st;
  logic           sclk_q, conv_q, bip_q;
  logic [RCW-1:0] rc;
  logic [2:0]     pc, goal;
  logic [WCW-1:0] wc;
  logic           tick, tick_en, start_ok, cap_shift;
  logic [DW:0]    raw;

  assign tick_en  = (st != ST_IDLE) && (st != ST_HOLD);
  assign start_ok = (st == ST_IDLE) && conv_req;
  assign cap_shift = (st == ST_CLOCK) && tick && !sclk_q &&
                     (rc >= CAP_LO) && (rc < CAP_HI);

  half_tick #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(tick_en), .tick(tick)
  );

  bit_capture #(.BITS(DW + 1)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .shift(cap_shift),
    .din(sdata_i), .q(raw)
  );

  word_format #(.DW(DW), .OW(OW)) u_fmt (
    .raw(raw), .bip(bip_q), .word(res_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sclk_q <= 1'b0;
      conv_q <= 1'b0;
      bip_q  <= 1'b0;
      rc     <= '0;
      pc     <= '0;
      goal   <= '0;
      wc     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (conv_req) begin
            st     <= ST_SETUP;
            conv_q <= 1'b1;
            bip_q  <= bipolar;
            rc     <= '0;
          end else if (sleep_req || nap_req) begin
            st     <= ST_PWR_HI;
            conv_q <= 1'b1;
            pc     <= '0;
            goal   <= sleep_req ? 3'(SLEEP_PULSES) : 3'(NAP_PULSES);
          end else if (wake_req) begin
            st     <= ST_WAKE;
            sclk_q <= 1'b1;
            wc     <= '0;
          end
        end
        ST_SETUP: if (tick) begin
          conv_q <= 1'b0;
          st     <= ST_CLOCK;
        end
        ST_CLOCK: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rc     <= rc + 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (rc == RC_LAST) st <= ST_HOLD;
          end
        end
        ST_HOLD: if (res_ready) st <= ST_IDLE;
        ST_PWR_HI: if (tick) begin
          conv_q <= 1'b0;
          pc     <= pc + 1'b1;
          st     <= ST_PWR_LO;
        end
        ST_PWR_LO: if (tick) begin
          if (pc == goal) begin
            st <= ST_IDLE;
          end else begin
            conv_q <= 1'b1;
            st     <= ST_PWR_HI;
          end
        end
        ST_WAKE: if (tick) begin
          if (wc == WAKE_END) begin
            sclk_q <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            wc <= wc + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign conv_o    = conv_q;
  assign sclk_o    = sclk_q;
  assign res_valid = (st == ST_HOLD);
endmodule

// File: rtl/adc_link_ctrl_chk.sv
module adc_link_ctrl_chk #(
  parameter int unsigned OW         = 16,
  parameter int unsigned FRAME_CLKS = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_req,
  input logic          nap_req,
  input logic          sleep_req,
  input logic          wake_req,
  input logic          bipolar,
  input logic          busy,
  input logic          conv_o,
  input logic          sclk_o,
  input logic          sdata_i,
  input logic          res_valid,
  input logic          res_ready,
  input logic [OW-1:0] res_data
);
  logic       conv_d, sclk_d, valid_d;
  logic [7:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_d  <= 1'b0;
      sclk_d  <= 1'b0;
      valid_d <= 1'b0;
      rises   <= '0;
    end else begin
      conv_d  <= conv_o;
      sclk_d  <= sclk_o;
      valid_d <= res_valid;
      if (conv_o && !conv_d)      rises <= '0;
      else if (sclk_o && !sclk_d) rises <= rises + 1'b1;
    end
  end

  AST_STROBE_CLOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_o && sclk_o)); // R2

  AST_FRAME_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !valid_d) |-> (rises == 8'(FRAME_CLKS))); // R2

  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (!conv_o && !sclk_o)); // R1

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data))); // R6

  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy); // R6

  AST_SIGN_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(res_data[OW-1:OW-3]) == 0 ||
                   $countones(res_data[OW-1:OW-3]) == 3)); // R5

  AST_NO_SCLK_WHILE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> !sclk_o); // R8
endmodule

bind adc_link_ctrl adc_link_ctrl_chk #(.OW(OW), .FRAME_CLKS(FRAME_CLKS)) u_chk (.*);

// File: tb/adc_link_ctrl_test.sv
module adc_link_ctrl_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_req = 1'b0, nap_req = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
  logic        bipolar = 1'b0;
  logic        busy, conv_o, sclk_o, res_valid;
  logic        sdata_i = 1'b0;
  logic        res_ready = 1'b0;
  logic [15:0] res_data;

  int total = 0;
  int bad = 0;

  adc_link_ctrl uut (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .nap_req(nap_req),
    .sleep_req(sleep_req), .wake_req(wake_req), .bipolar(bipolar),
    .busy(busy), .conv_o(conv_o), .sclk_o(sclk_o), .sdata_i(sdata_i),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  always #(PERIOD/2) clk = ~clk;

  // converter model
  logic        m_rdy = 1'b0;
  logic [11:0] m_word = '0;
  int sclk_total = 0;
  int conv_total = 0;
  int k_base = 0;
  int early_bad = 0;

  always @(posedge conv_o) begin
    conv_total = conv_total + 1;
    k_base = sclk_total;
  end

  always @(posedge sclk_o) begin
    int k;
    sclk_total = sclk_total + 1;
    k = sclk_total - k_base;
    if (k == 1 && conv_o) early_bad = early_bad + 1;
    #1;
    if (k == 2)                sdata_i = m_rdy;
    else if (k >= 3 && k <= 14) sdata_i = m_word[14 - k];
    else                        sdata_i = 1'b0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 400 && !res_valid; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic accept();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  // {bipolar, ready, data[11:0], expected[15:0]}
  localparam logic [29:0] VEC [7] = '{
    {1'b0, 1'b1, 12'h000, 16'h1000},
    {1'b0, 1'b1, 12'hFFF, 16'h1FFF},
    {1'b0, 1'b0, 12'hA5C, 16'h0A5C},
    {1'b1, 1'b1, 12'h800, 16'hF800},
    {1'b1, 1'b1, 12'h7FF, 16'h17FF},
    {1'b1, 1'b0, 12'hFFF, 16'hEFFF},
    {1'b0, 1'b1, 12'h001, 16'h1001}
  };

  initial begin
    #(PERIOD * 150000);
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0, s0, hi;
    logic [15:0] snap;
    repeat (3) @(negedge clk);
    check("R1 conv", {31'b0, conv_o}, 0);
    check("R1 sclk", {31'b0, sclk_o}, 0);
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 valid", {31'b0, res_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      bipolar = VEC[i][29];
      m_rdy   = VEC[i][28];
      m_word  = VEC[i][27:16];
      s0 = sclk_total;
      conv_req = 1'b1;
      @(negedge clk);
      conv_req = 1'b0;
      bipolar = ~bipolar;  // format latched at start
      wait_valid();
      check(VEC[i][29] ? "R5 R3 word" : "R4 R3 word", {16'b0, res_data}, {16'b0, VEC[i][15:0]});
      check("R2 edges", sclk_total - s0, 16);
      accept();
    end
    check("R2 strobe low before first edge", early_bad, 0);

    // R6 back-pressure
    bipolar = 1'b0; m_rdy = 1'b1; m_word = 12'h3C3;
    conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
    wait_valid();
    snap = res_data;
    repeat (6) @(negedge clk);
    check("R6 valid held", {31'b0, res_valid}, 1);
    check("R6 busy held", {31'b0, busy}, 1);
    check("R6 data stable", {16'b0, res_data}, {16'b0, snap});
    check("R6 data value", {16'b0, res_data}, 32'h13C3);
    accept();
    @(negedge clk);
    check("R6 released", {31'b0, res_valid}, 0);

    // R7 requests while busy ignored
    c0 = conv_total; s0 = sclk_total;
    conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
    repeat (12) @(negedge clk);
    conv_req = 1'b1; sleep_req = 1'b1; wake_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
    wait_valid();
    conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
    accept();
    wait_idle();
    repeat (10) @(negedge clk);
    check("R7 strobes", conv_total - c0, 1);
    check("R7 edges", sclk_total - s0, 16);
    check("R7 idle", {31'b0, busy}, 0);

    // R8 nap
    c0 = conv_total; s0 = sclk_total;
    nap_req = 1'b1; @(negedge clk); nap_req = 1'b0;
    wait_idle();
    check("R8 strobes", conv_total - c0, 2);
    check("R8 edges", sclk_total - s0, 0);

    // R9 sleep
    c0 = conv_total; s0 = sclk_total;
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    wait_idle();
    check("R9 strobes", conv_total - c0, 4);
    check("R9 edges", sclk_total - s0, 0);

    // R10 wake
    c0 = conv_total; s0 = sclk_total; hi = 0;
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (sclk_o) hi = hi + 1;
      @(negedge clk);
    end
    check("R10 edges", sclk_total - s0, 1);
    check("R10 width", hi, 4);
    check("R10 strobes", conv_total - c0, 0);

    // R11 priority
    c0 = conv_total; s0 = sclk_total;
    bipolar = 1'b1; m_rdy = 1'b0; m_word = 12'h123;
    conv_req = 1'b1; sleep_req = 1'b1; nap_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0; sleep_req = 1'b0; nap_req = 1'b0;
    wait_valid();
    check("R11 conv wins word", {16'b0, res_data}, 32'h0123);
    accept();
    wait_idle();
    check("R11 conv wins strobes", conv_total - c0, 1);
    check("R11 conv wins edges", sclk_total - s0, 16);

    c0 = conv_total; s0 = sclk_total;
    sleep_req = 1'b1; nap_req = 1'b1; @(negedge clk);
    sleep_req = 1'b0; nap_req = 1'b0;
    wait_idle();
    check("R11 sleep over nap", conv_total - c0, 4);

    c0 = conv_total; s0 = sclk_total;
    nap_req = 1'b1; wake_req = 1'b1; @(negedge clk);
    nap_req = 1'b0; wake_req = 1'b0;
    wait_idle();
    check("R11 nap over wake strobes", conv_total - c0, 2);
    check("R11 nap over wake edges", sclk_total - s0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule